// File: doc/BRIEF.md
# External Data Bus Sequencer with Adjustable Access Length

This block runs one external data-memory transfer at a time on a multiplexed address/data bus of the classic 8-bit microcontroller kind. The core hands it a request made of a 16-bit address, a direction flag and a write byte. The block then pulses the address-latch strobe while the low address byte sits on the shared bus. It drives the upper address byte for the whole transfer and opens an active-low read or write strobe. It captures the read byte and ends with a one-clock done pulse.

The length of each transfer is set by a 3-bit stretch field in a clock-control register, written through a small register port at address 8Eh. A transfer lasts 2 + stretch machine cycles of 4 clocks each, so slow memories and peripherals can be reached without glue logic. The reset value of the field is 1, not full speed. A request can instead take its upper address byte from an externally held port-latch value, which serves accesses addressed by an 8-bit pointer. The program-store enable output stays high for the whole time, because this block only serves data memory.

Top module: `xbus_sequencer`

## Requirements
- R1: After reset, rd_n, wr_n and psen_n are 1, ale, bus_oe, busy and done are 0, and the stretch field holds 1.
- R2: A register write with cfg_addr equal to 8'h8E loads cfg_wdata (the 3-bit stretch field) into the stretch register. A write to any other address leaves the field unchanged.
- R3: A transfer with stretch s lasts 4*(2+s) clocks, counted from the first clock with ale high. done is high for exactly the last of those clocks, and busy is high for all of them.
- R4: ale is high for the first 2 clocks of a transfer and only then. During those clocks bus_oe is 1 and bus_out carries req_addr[7:0].
- R5: The strobe goes low at clock 4 of the transfer (counting from 0). It stays low for 2 clocks when s is 0, and for 4*s clocks otherwise.
- R6: On a write, only wr_n pulses and rd_n stays 1. From clock 2 to the end of the transfer bus_oe is 1 and bus_out equals the write byte, so the data settles before wr_n falls and holds after it rises.
- R7: On a read, only rd_n pulses and bus_oe is 0 from clock 2 on. rdata takes bus_in at the clock edge that ends the last low clock of rd_n, and it is valid while done is high.
- R8: For the whole transfer, addr_hi equals req_addr[15:8] when req_page is 0, and the value of p2_latch at request time when req_page is 1.
- R9: psen_n is 1 at all times.
- R10: The stretch value is taken when a request is accepted. A register write during a transfer changes only the length of later transfers.
- R11: A request is accepted only when busy is 0. A request raised during a transfer is dropped and does not start a later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register write address |
| cfg_wdata | input | 3 | Stretch value to write |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_page | input | 1 | 1 = upper address from p2_latch |
| req_addr | input | 16 | Transfer address |
| req_wdata | input | 8 | Write byte |
| p2_latch | input | 8 | Held upper-port latch value |
| bus_in | input | 8 | Value read from the shared bus |
| busy | output | 1 | Transfer in progress |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program-store enable, held high |
| bus_out | output | 8 | Value driven on the shared bus |
| bus_oe | output | 1 | Shared bus output enable |
| addr_hi | output | 8 | Upper address byte |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | Last clock of a transfer |

## Verification
The hardest case to reach is a stretch change that lands inside a running transfer, together with a second request that arrives while the block is busy. Both must leave the current transfer's length and the later idle period untouched. The bench forks a register write, or a stray request, a few clocks into a transfer it is measuring. It then checks that transfer's clock count and the following transfer's clock count, and also that busy stays low after done. Every stretch value from 0 to 7 is also covered by the vector table, each with its own expected length and strobe width.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  localparam int MC_CLKS   = 4;
  localparam int STRETCH_W = 3;
  localparam int ADDR_W    = 16;
  localparam int DATA_W    = 8;
  localparam int HALF_W    = ADDR_W / 2;
  localparam int ADDR_CLKS = MC_CLKS / 2;
  localparam int MAX_CLKS  = MC_CLKS * (2 + (1 << STRETCH_W) - 1);
  localparam int PH_W      = $clog2(MAX_CLKS + 1);

  typedef logic [STRETCH_W-1:0] stretch_t;
  typedef logic [PH_W-1:0]      phase_t;

  typedef struct packed {
    logic              wr;
    logic [HALF_W-1:0] lo;
    logic [HALF_W-1:0] hi;
    logic [DATA_W-1:0] wdata;
    stretch_t          stretch;
  } xfer_t;

  function automatic phase_t access_len(input stretch_t s);
    return PH_W'(MC_CLKS * (2 + int'(s)));
  endfunction

  function automatic phase_t strobe_len(input stretch_t s);
    return (s == '0) ? PH_W'(MC_CLKS / 2) : PH_W'(MC_CLKS * int'(s));
  endfunction

  function automatic phase_t strobe_first();
    return PH_W'(MC_CLKS);
  endfunction

  function automatic phase_t strobe_last(input stretch_t s);
    return PH_W'(MC_CLKS) + strobe_len(s) - PH_W'(1);
  endfunction
endpackage

// File: rtl/xbus_stretch_reg.sv
module xbus_stretch_reg
  import xbus_pkg::*;
#(
  parameter logic [7:0] CFG_ADDR  = 8'h8E,
  parameter int         RESET_VAL = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [7:0] cfg_addr,
  input  stretch_t   cfg_wdata,
  output stretch_t   stretch
);
  logic hit;
  assign hit = cfg_we && (cfg_addr == CFG_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stretch <= STRETCH_W'(RESET_VAL);
    else if (hit) stretch <= cfg_wdata;
  end

  p_reg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(stretch));
endmodule

// File: rtl/xbus_timer.sv
module xbus_timer
  import xbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  phase_t len,
  output logic   active,
  output phase_t phase,
  output logic   last
);
  assign last = active && (phase == len - PH_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phase  <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        phase  <= '0;
      end
    end else if (last) begin
      active <= 1'b0;
      phase  <= '0;
    end else begin
      phase <= phase + PH_W'(1);
    end
  end

  p_done_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active);
  p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (phase < len));
  p_busy_runs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> (active && phase == $past(phase) + PH_W'(1)));
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  phase_t            phase,
  input  xfer_t             xfer,
  input  logic [DATA_W-1:0] bus_in,
  output logic              ale,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rdata
);
  logic in_addr, strobe_on, sample_evt, data_phase;
  phase_t last_clk;

  assign last_clk   = strobe_last(xfer.stretch);
  assign in_addr    = active && (phase < PH_W'(ADDR_CLKS));
  assign data_phase = active && !in_addr;
  assign strobe_on  = active && (phase >= strobe_first()) && (phase <= last_clk);
  assign sample_evt = strobe_on && !xfer.wr && (phase == last_clk);

  assign ale    = in_addr;
  assign rd_n   = !(strobe_on && !xfer.wr);
  assign wr_n   = !(strobe_on && xfer.wr);
  assign bus_oe = in_addr || (data_phase && xfer.wr);

  always_comb begin
    if (in_addr)                       bus_out = xfer.lo;
    else if (data_phase && xfer.wr)    bus_out = xfer.wdata;
    else                               bus_out = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (sample_evt) rdata <= bus_in;
  end

  p_strobes_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));
  p_wr_data_driven_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (bus_oe && !ale));
  p_ale_drives_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (bus_oe && rd_n && wr_n));
  p_rd_released_after_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> rd_n);
  p_read_bus_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);
endmodule

// File: rtl/xbus_sequencer.sv
module xbus_sequencer
  import xbus_pkg::*;
#(
  parameter logic [7:0] CFG_ADDR      = 8'h8E,
  parameter int         RESET_STRETCH = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_addr,
  input  logic [2:0]        cfg_wdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_page,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  input  logic [7:0]        p2_latch,
  input  logic [7:0]        bus_in,
  output logic              busy,
  output logic              ale,
  output logic              psen_n,
  output logic [7:0]        bus_out,
  output logic              bus_oe,
  output logic [7:0]        addr_hi,
  output logic              rd_n,
  output logic              wr_n,
  output logic [7:0]        rdata,
  output logic              done
);
  stretch_t stretch;
  xfer_t    xfer_q;
  logic     active, last, accept;
  phase_t   phase;

  xbus_stretch_reg #(.CFG_ADDR(CFG_ADDR), .RESET_VAL(RESET_STRETCH)) u_reg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .stretch(stretch)
  );

  assign accept = req_valid && !active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= '0;
    end else if (accept) begin
      xfer_q.wr      <= req_write;
      xfer_q.lo      <= req_addr[HALF_W-1:0];
      xfer_q.hi      <= req_page ? p2_latch : req_addr[ADDR_W-1:HALF_W];
      xfer_q.wdata   <= req_wdata;
      xfer_q.stretch <= stretch;
    end
  end

  xbus_timer u_timer (
    .clk(clk), .rst_n(rst_n), .start(accept), .len(access_len(xfer_q.stretch)),
    .active(active), .phase(phase), .last(last)
  );

  xbus_strobe_gen u_strobe (
    .clk(clk), .rst_n(rst_n), .active(active), .phase(phase), .xfer(xfer_q),
    .bus_in(bus_in), .ale(ale), .bus_out(bus_out), .bus_oe(bus_oe),
    .rd_n(rd_n), .wr_n(wr_n), .rdata(rdata)
  );

  assign busy    = active;
  assign done    = last;
  assign addr_hi = xfer_q.hi;
  assign psen_n  = 1'b1;

  p_psen_high_r9: assert property (@(posedge clk) disable iff (!rst_n) psen_n);
  p_snapshot_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !last) |=> $stable(xfer_q));
  p_strobe_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (busy && !ale && !done));
endmodule

// File: tb/tb_xbus_sequencer.sv
module tb_xbus_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [7:0] cfg_addr = 0; logic [2:0] cfg_wdata = 0;
  logic req_valid = 0, req_write = 0, req_page = 0;
  logic [15:0] req_addr = 0; logic [7:0] req_wdata = 0, p2_latch = 0, bus_in = 0;
  logic busy, ale, psen_n, bus_oe, rd_n, wr_n, done;
  logic [7:0] bus_out, addr_hi, rdata;

  int checks = 0, errors = 0, cycles = 0;

  always #4 clk = ~clk;

  xbus_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_page(req_page), .req_addr(req_addr),
    .req_wdata(req_wdata), .p2_latch(p2_latch), .bus_in(bus_in), .busy(busy), .ale(ale),
    .psen_n(psen_n), .bus_out(bus_out), .bus_oe(bus_oe), .addr_hi(addr_hi), .rd_n(rd_n),
    .wr_n(wr_n), .rdata(rdata), .done(done)
  );

  typedef struct packed {
    logic [2:0] s; logic cfg; logic wr; logic pg;
    logic [15:0] a; logic [7:0] d; logic [7:0] p2;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{3'd1, 1'b0, 1'b0, 1'b0, 16'h1234, 8'hA5, 8'h00},
    '{3'd0, 1'b1, 1'b1, 1'b0, 16'hBEEF, 8'h3C, 8'h11},
    '{3'd0, 1'b1, 1'b0, 1'b0, 16'h0001, 8'h5A, 8'h00},
    '{3'd2, 1'b1, 1'b1, 1'b1, 16'h00C3, 8'h81, 8'h7E},
    '{3'd3, 1'b1, 1'b0, 1'b1, 16'hFF10, 8'h6D, 8'h22},
    '{3'd5, 1'b1, 1'b1, 1'b0, 16'h8000, 8'hFF, 8'h00},
    '{3'd7, 1'b1, 1'b0, 1'b0, 16'hFFFF, 8'h00, 8'h00},
    '{3'd7, 1'b1, 1'b1, 1'b0, 16'h4321, 8'h99, 8'h44},
    '{3'd4, 1'b1, 1'b0, 1'b0, 16'h55AA, 8'hC9, 8'h00},
    '{3'd6, 1'b1, 1'b1, 1'b0, 16'h0F0F, 8'h0F, 8'h00}
  };

  function automatic int exp_len(input int s); return 4 * s + 8; endfunction
  function automatic int exp_strobe(input int s); return (s == 0) ? 2 : 4 * s; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [2:0] v);
    @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  // Runs one transfer and measures it at the ports.
  task automatic run_xfer(input vec_t v, input int s_exp);
    int n, ale_n, ale_bad, st_n, st_first, hi_bad, oe_bad, wr_rd_bad, psen_bad;
    int wdat, alo, aoe;
    logic [7:0] hi_exp;
    n = 0; ale_n = 0; ale_bad = 0; st_n = 0; st_first = -1; hi_bad = 0;
    oe_bad = 0; wr_rd_bad = 0; psen_bad = 0; wdat = -1; alo = -1; aoe = 0;
    hi_exp = v.pg ? v.p2 : v.a[15:8];
    @(negedge clk);
    req_valid = 1; req_write = v.wr; req_page = v.pg; req_addr = v.a;
    req_wdata = v.d; p2_latch = v.p2; bus_in = v.d;
    @(negedge clk);
    req_valid = 0; p2_latch = ~v.p2;
    forever begin
      if (ale) begin
        ale_n++;
        if (n > 1) ale_bad++;
        if (n == 0) begin alo = bus_out; aoe = bus_oe; end
      end
      if ((v.wr ? wr_n : rd_n) == 1'b0) begin
        if (st_first < 0) begin st_first = n; wdat = bus_out; end
        st_n++;
      end
      if ((v.wr ? rd_n : wr_n) == 1'b0) wr_rd_bad++;
      if (n >= 2 && (bus_oe !== v.wr || (v.wr && bus_out !== v.d))) oe_bad++;
      if (addr_hi !== hi_exp) hi_bad++;
      if (!psen_n) psen_bad++;
      if (!busy) begin
        chk(0, "R3 busy dropped early", n, exp_len(s_exp)); return;
      end
      n++;
      if (done || n > 60) break;
      @(negedge clk);
    end
    chk(n == exp_len(s_exp), "R3 transfer length", n, exp_len(s_exp));
    chk(ale_n == 2 && ale_bad == 0, "R4 ale pulse", ale_n, 2);
    chk(alo == int'(v.a[7:0]) && aoe == 1, "R4 low address on bus", alo, v.a[7:0]);
    chk(st_first == 4, "R5 strobe start", st_first, 4);
    chk(st_n == exp_strobe(s_exp), "R5 strobe width", st_n, exp_strobe(s_exp));
    chk(wr_rd_bad == 0, v.wr ? "R6 rd_n quiet on write" : "R7 wr_n quiet on read", wr_rd_bad, 0);
    chk(oe_bad == 0, v.wr ? "R6 write data driven" : "R7 bus released", oe_bad, 0);
    if (v.wr) chk(wdat == int'(v.d), "R6 data at strobe", wdat, v.d);
    else      chk(rdata === v.d, "R7 read data", rdata, v.d);
    chk(hi_bad == 0, "R8 upper address", addr_hi, hi_exp);
    chk(psen_bad == 0, "R9 psen_n high", psen_bad, 0);
    @(negedge clk);
    chk(!busy && !done, "R3 idle after done", busy, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 50000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    vec_t w;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_n && wr_n && psen_n, "R1 strobes idle", {rd_n, wr_n, psen_n}, 7);
    chk(!ale && !bus_oe && !busy && !done, "R1 bus idle", {ale, bus_oe, busy, done}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(rd_n && wr_n && !ale && !busy, "R1 idle after release", {rd_n, wr_n, ale, busy}, 12);

    // Vector table: first entry uses the reset stretch value of 1 (R1)
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].cfg) cfg_write(8'h8E, VECS[i].s);
      run_xfer(VECS[i], int'(VECS[i].s));
    end

    // R2: a write to another address leaves the stretch at 6
    cfg_write(8'h8D, 3'd0);
    w = '{3'd6, 1'b0, 1'b0, 1'b0, 16'h2468, 8'h42, 8'h00};
    run_xfer(w, 6);

    // R10: stretch change in the middle of a transfer
    cfg_write(8'h8E, 3'd1);
    w = '{3'd1, 1'b0, 1'b1, 1'b0, 16'h1357, 8'h24, 8'h00};
    fork
      run_xfer(w, 1);
      begin repeat (3) @(negedge clk); cfg_write(8'h8E, 3'd5); end
    join
    w = '{3'd5, 1'b0, 1'b0, 1'b0, 16'h9753, 8'hE1, 8'h00};
    run_xfer(w, 5);

    // R11: request raised during a busy transfer is dropped
    w = '{3'd5, 1'b0, 1'b1, 1'b0, 16'hAAAA, 8'h18, 8'h00};
    fork
      run_xfer(w, 5);
      begin
        repeat (5) @(negedge clk);
        req_valid = 1; req_addr = 16'h7777;
        @(negedge clk); req_valid = 0;
      end
    join
    for (int k = 0; k < 4; k++) begin
      chk(!busy && !ale, "R11 stray request dropped", busy, 0);
      @(negedge clk);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule